// File: doc/BRIEF.md
# Break and Sync Baud Rate Detector

This block watches an already synchronised serial receive line for a long low level (a break) and for the 0x55 sync character that follows it, and from that character it derives the bit period in system clocks. The result is offered to the baud rate logic as a divisor with a one-cycle valid strobe, so a receiver can lock on to a sender whose rate it did not know beforehand.

Whether a low level is long enough to count as a break is judged in bit-times of the bit period currently programmed on `cur_period`. A break that stays low for too long is reported as a break-timeout error, and a sync character that takes longer than the measurement counter can hold is reported as a sync-timeout error. While a candidate break or the sync character is on the line, `tx_hold` tells the local transmitter to stay quiet. When measuring is turned off, the sync character is still followed to its end, but no divisor is produced and no sync timeout can occur.

Top module: `autobaud_det`

## Requirements
- R1: After reset, all event outputs are low, `div_out` is zero and `tx_hold` is low.
- R2: With `cur_period` = P, a low level lasting at least 11·P sampled clocks and then a high sample gives a single `brk_seen` pulse, which is visible after the clock edge that samples the high level.
- R3: A low level of fewer than 11·P samples gives no event. The block then returns to idle, and `tx_hold` falls after the first high sample. A sync character that is not preceded by a valid break produces no divisor.
- R4: If the line is still low on sample 21·P+1 of a break, `brk_tmo` pulses on that sample and `brk_seen` never follows. The block then waits for the line to go high before it returns to idle.
- R5: After a break, the sync character 0x55 is sent LSB first: a low start bit, data bits 1,0,1,0,1,0,1,0, then a high stop bit. The block counts the clocks from the first falling edge to the fifth falling edge. It pulses `div_valid` on the sample of the fifth falling edge with `div_out` = count >> 3, and `div_out` keeps that value until the next valid pulse.
- R6: With `meas_en` low, a break and sync character give only `brk_seen`. No `div_valid` or `sync_tmo` occurs, `div_out` keeps its previous value, and `tx_hold` falls once the line returns high after the fifth falling edge.
- R7: The measurement counter is CNT_W bits wide (16 by default) and saturates. If it reaches all ones before the fifth falling edge, `sync_tmo` pulses on the next sample (sample 65536 after the first falling edge, by default) and no divisor is given.
- R8: `tx_hold` is high from the sample after the first low sample of a candidate break until the line is back high after the sync character or the error that ended the sequence.
- R9: While `det_en` is low the line is ignored: no event and no `tx_hold`. Dropping `det_en` in mid-sequence brings `tx_hold` low after the next clock edge.
- R10: A sync span that is not a multiple of 8 clocks is truncated: a span of 83 clocks gives `div_out` = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Synchronised receive line, idle high |
| det_en | input | 1 | Enables break and sync detection |
| meas_en | input | 1 | Enables measurement of the sync character |
| cur_period | input | PER_W (16) | Programmed bit period in clocks, used to judge break length; at least 1 |
| div_out | output | CNT_W-3 (13) | Measured bit period in clocks |
| div_valid | output | 1 | One-cycle strobe: a new `div_out` value is available |
| brk_seen | output | 1 | One-cycle pulse: a valid break has ended |
| brk_tmo | output | 1 | One-cycle pulse: the break was too long |
| sync_tmo | output | 1 | One-cycle pulse: the sync measurement saturated |
| tx_hold | output | 1 | Transmitter inhibit while a break or sync character is in progress |

## Verification
Every result is registered, so each one becomes visible one clock after the edge that samples the deciding line level. For `brk_seen`, that edge samples the first high level. For `brk_tmo`, it samples low number 21·P+1. For `div_valid`, it samples the fifth falling edge. For `sync_tmo`, it comes 65536 samples after the first falling edge. The bench changes `rx_in` on falling clock edges and counts the samples it drives. It places point checks on the exact falling edge where a pulse must first appear, and one edge earlier where the pulse must still be absent. A scoreboard monitor compares every pulse, and its divisor, against the event the driver queued for it, so an event that comes early, comes late, comes twice or was never expected shows up as a mismatch.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_BRK   = 3'd1,
    S_GAP   = 3'd2,
    S_MEAS  = 3'd3,
    S_DRAIN = 3'd4
  } abd_state_e;
endpackage

// File: rtl/abd_brk_timer.sv
module abd_brk_timer #(
  parameter int PER_W = 16,
  parameter int BIT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic [BIT_W-1:0] bits
);
  localparam logic [BIT_W-1:0] BITS_MAX = '1;

  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] base_phase;
  logic [BIT_W-1:0] base_bits;
  logic             phase_wrap;

  // A new run starts from zero whenever clear is asserted.
  assign base_phase = clear ? '0 : phase;
  assign base_bits  = clear ? '0 : bits;
  assign phase_wrap = (base_phase == period - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      bits  <= '0;
    end else if (run) begin
      if (phase_wrap) begin
        phase <= '0;
        bits  <= (base_bits == BITS_MAX) ? base_bits : base_bits + BIT_W'(1);
      end else begin
        phase <= base_phase + PER_W'(1);
        bits  <= base_bits;
      end
    end else if (clear) begin
      phase <= '0;
      bits  <= '0;
    end
  end

  assert_bits_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(bits));
endmodule

// File: rtl/abd_sync_meter.sv
module abd_sync_meter #(
  parameter int CNT_W  = 16,
  parameter int FALL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              cnt_en,
  input  logic              fall,
  output logic [CNT_W-1:0]  cnt,
  output logic [FALL_W-1:0] falls,
  output logic              sat
);
  assign sat = (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      falls <= '0;
    end else if (start) begin
      cnt   <= '0;
      falls <= '0;
    end else if (run) begin
      if (fall)
        falls <= falls + FALL_W'(1);
      if (cnt_en && !sat)
        cnt <= cnt + CNT_W'(1);
    end
  end

  assert_cnt_holds_at_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && sat) |=> sat);
endmodule

// File: rtl/autobaud_det.sv
module autobaud_det
  import abd_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int CNT_W      = 16,
  parameter int BRK_BITS   = 11,
  parameter int BTO_BITS   = 21,
  parameter int SYNC_FALLS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             det_en,
  input  logic             meas_en,
  input  logic [PER_W-1:0] cur_period,
  output logic [CNT_W-4:0] div_out,
  output logic             div_valid,
  output logic             brk_seen,
  output logic             brk_tmo,
  output logic             sync_tmo,
  output logic             tx_hold
);
  localparam int BIT_W  = $clog2(BTO_BITS + 2);
  localparam int FALL_W = $clog2(SYNC_FALLS);
  localparam int DIV_W  = CNT_W - 3;

  // Saturating increment: converts "cycles after first edge" into the span.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] m);
    return (m == '1) ? m : m + CNT_W'(1);
  endfunction

  // The span from the first to the last falling edge of 0x55 covers 8 bits.
  function automatic logic [DIV_W-1:0] div_of(input logic [CNT_W-1:0] span);
    return DIV_W'(span >> 3);
  endfunction

  abd_state_e state;

  // Named internal events.
  logic              rx_q;
  logic              line_low;
  logic              rx_fall;
  logic              brk_run;
  logic              brk_clr;
  logic [BIT_W-1:0]  brk_bits;
  logic              brk_long_enough;
  logic              brk_over;
  logic              meas_start;
  logic              meas_run;
  logic [CNT_W-1:0]  meas_cnt;
  logic [FALL_W-1:0] meas_falls;
  logic              meas_sat;
  logic              sync_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_in;
  end

  assign line_low        = !rx_in;
  assign rx_fall         = rx_q && !rx_in;
  assign brk_clr         = (state == S_IDLE);
  assign brk_run         = det_en && line_low && (state == S_IDLE || state == S_BRK);
  assign brk_long_enough = (brk_bits >= BIT_W'(BRK_BITS));
  assign brk_over        = (brk_bits >= BIT_W'(BTO_BITS));
  assign meas_start      = det_en && (state == S_GAP) && rx_fall;
  assign meas_run        = (state == S_MEAS);
  assign sync_done       = meas_run && rx_fall && (meas_falls == FALL_W'(SYNC_FALLS - 2));

  abd_brk_timer #(.PER_W(PER_W), .BIT_W(BIT_W)) u_brk_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (brk_clr),
    .run    (brk_run),
    .period (cur_period),
    .bits   (brk_bits)
  );

  abd_sync_meter #(.CNT_W(CNT_W), .FALL_W(FALL_W)) u_sync_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (meas_start),
    .run    (meas_run),
    .cnt_en (meas_en),
    .fall   (rx_fall),
    .cnt    (meas_cnt),
    .falls  (meas_falls),
    .sat    (meas_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      div_out   <= '0;
      div_valid <= 1'b0;
      brk_seen  <= 1'b0;
      brk_tmo   <= 1'b0;
      sync_tmo  <= 1'b0;
    end else begin
      div_valid <= 1'b0;
      brk_seen  <= 1'b0;
      brk_tmo   <= 1'b0;
      sync_tmo  <= 1'b0;
      if (!det_en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (line_low) state <= S_BRK;
          S_BRK: begin
            if (line_low) begin
              if (brk_over) begin
                brk_tmo <= 1'b1;
                state   <= S_DRAIN;
              end
            end else if (brk_long_enough) begin
              brk_seen <= 1'b1;
              state    <= S_GAP;
            end else begin
              state <= S_IDLE;
            end
          end
          S_GAP: if (rx_fall) state <= S_MEAS;
          S_MEAS: begin
            if (sync_done) begin
              if (meas_en) begin
                div_valid <= 1'b1;
                div_out   <= div_of(sat_inc(meas_cnt));
              end
              state <= S_DRAIN;
            end else if (meas_en && meas_sat) begin
              sync_tmo <= 1'b1;
              state    <= S_DRAIN;
            end
          end
          S_DRAIN: if (!line_low) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign tx_hold = (state != S_IDLE);

  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_seen, brk_tmo, sync_tmo, div_valid}));
  assert_hold_after_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_seen |-> tx_hold);
  assert_valid_needs_meas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> $past(meas_en));
  assert_div_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_valid |-> $stable(div_out));
  assert_idle_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !tx_hold);
endmodule

// File: tb/autobaud_det_bench.sv
module autobaud_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EV_BRK = 0, EV_BTO = 1, EV_STO = 2, EV_DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b1;
  logic        det_en = 1'b1;
  logic        meas_en = 1'b1;
  logic [15:0] cur_period = 16'd8;
  logic [12:0] div_out;
  logic        div_valid, brk_seen, brk_tmo, sync_tmo, tx_hold;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { int kind; int val; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_det u_autobaud_det (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .det_en(det_en), .meas_en(meas_en),
    .cur_period(cur_period), .div_out(div_out), .div_valid(div_valid),
    .brk_seen(brk_seen), .brk_tmo(brk_tmo), .sync_tmo(sync_tmo), .tx_hold(tx_hold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic take(input int kind, input int val);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind && e.val == val, e.tag, kind * 100000 + val, e.kind * 100000 + e.val);
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (brk_seen)  take(EV_BRK, 0);
      if (brk_tmo)   take(EV_BTO, 0);
      if (sync_tmo)  take(EV_STO, 0);
      if (div_valid) take(EV_DIV, int'(div_out));
    end
  end

  task automatic line(input logic lvl, input int n);
    rx_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  // 0x55 LSB first; the start bit may be stretched to first_len samples.
  task automatic send_frame(input int first_len, input int q);
    line(1'b0, first_len);
    for (int i = 0; i < 8; i++) line(((8'h55 >> i) & 1) != 0, q);
    line(1'b1, q);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(div_out == 0 && !div_valid && !brk_seen && !brk_tmo && !sync_tmo, "R1 reset outputs",
        int'(div_out), 0);
    chk(tx_hold == 0, "R1 tx_hold at reset", tx_hold, 0);
    rst_n = 1'b1;
    line(1'b1, 4);

    // R3: short low, then an unprefixed sync frame.
    line(1'b0, 40);
    chk(tx_hold == 1, "R8 hold during candidate break", tx_hold, 1);
    line(1'b0, 47);
    line(1'b1, 1);
    chk(tx_hold == 0, "R3 idle after short low", tx_hold, 0);
    send_frame(10, 10);
    line(1'b1, 4);
    chk(tx_hold == 0, "R3 no sync without break", tx_hold, 0);

    // R2 boundary 11*P, R5 sync at 13 clocks per bit.
    line(1'b0, 88);
    expect_ev(EV_BRK, 0, "R2 break at 11 bit-times");
    line(1'b1, 1);
    chk(brk_seen == 1, "R2 break pulse timing", brk_seen, 1);
    line(1'b1, 7);
    expect_ev(EV_DIV, 13, "R5 divisor 13");
    send_frame(13, 13);
    line(1'b1, 1);
    chk(tx_hold == 0, "R8 hold released after sync", tx_hold, 0);
    chk(div_out == 13, "R5 divisor held", int'(div_out), 13);
    line(1'b1, 3);

    // R5 at 100 clocks per bit.
    line(1'b0, 96);
    expect_ev(EV_BRK, 0, "R2 break 12 bit-times");
    line(1'b1, 5);
    expect_ev(EV_DIV, 100, "R5 divisor 100");
    send_frame(100, 100);
    line(1'b1, 4);

    // R10: span 13 + 7*10 = 83 clocks.
    line(1'b0, 96);
    expect_ev(EV_BRK, 0, "R2 break before truncation");
    line(1'b1, 6);
    expect_ev(EV_DIV, 10, "R10 truncated divisor");
    send_frame(13, 10);
    line(1'b1, 4);

    // R4 break timeout at sample 21*P+1.
    line(1'b0, 168);
    chk(brk_tmo == 0 && tx_hold == 1, "R4 no timeout at 21 bit-times", brk_tmo, 0);
    expect_ev(EV_BTO, 0, "R4 break timeout");
    line(1'b0, 1);
    chk(brk_tmo == 1, "R4 timeout pulse timing", brk_tmo, 1);
    line(1'b0, 30);
    chk(tx_hold == 1, "R4 waits for high", tx_hold, 1);
    line(1'b1, 2);
    chk(tx_hold == 0, "R4 idle after high", tx_hold, 0);
    line(1'b1, 2);

    // R6 measurement disabled.
    meas_en = 1'b0;
    line(1'b0, 96);
    expect_ev(EV_BRK, 0, "R6 break still reported");
    line(1'b1, 8);
    send_frame(20, 20);
    line(1'b1, 2);
    chk(div_out == 10, "R6 divisor unchanged", int'(div_out), 10);
    chk(tx_hold == 0, "R6 sequence ends", tx_hold, 0);
    meas_en = 1'b1;
    line(1'b1, 2);

    // R9 detection disabled, then abort.
    det_en = 1'b0;
    line(1'b0, 200);
    chk(tx_hold == 0, "R9 ignored while disabled", tx_hold, 0);
    line(1'b1, 4);
    det_en = 1'b1;
    line(1'b0, 40);
    chk(tx_hold == 1, "R9 hold before abort", tx_hold, 1);
    det_en = 1'b0;
    @(negedge clk);
    chk(tx_hold == 0, "R9 abort drops hold", tx_hold, 0);
    rx_in = 1'b1;
    det_en = 1'b1;
    line(1'b1, 4);

    // R7 sync timeout.
    cur_period = 16'd4;
    line(1'b0, 48);
    expect_ev(EV_BRK, 0, "R7 break before timeout");
    line(1'b1, 4);
    line(1'b0, 4);
    line(1'b1, 65532);
    chk(sync_tmo == 0, "R7 no timeout before saturation", sync_tmo, 0);
    expect_ev(EV_STO, 0, "R7 sync timeout");
    line(1'b1, 1);
    chk(sync_tmo == 1, "R7 timeout pulse timing", sync_tmo, 1);
    line(1'b1, 2);
    chk(tx_hold == 0, "R7 idle after timeout", tx_hold, 0);

    line(1'b1, 4);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule